// File: doc/BRIEF.md
# IDE PIO Strobe Timing Engine

This block sets the timing of programmed-I/O data transfers for a legacy local-bus IDE host adapter. The host programs one byte per timer through a small I/O port window. Each byte holds two complemented clock counts. The active count sets how long the read or write strobe stays asserted. The recovery count sets how long the strobe then stays idle before the next transfer can start. Both counts are measured in local-bus clocks. How a byte maps to clock counts depends on the device variant, which is chosen at build time (single or dual channel). On the single-channel variant it also depends on a bus-speed pin that is sampled during reset.

A transfer requester raises `xfer_req` together with a direction, a port and a drive. The engine picks a timer channel from the control byte's mapping bit. It decodes that timer's byte at the moment the request is accepted and keeps the counts for the whole transfer. It then runs the active phase and the recovery phase, and signals `xfer_busy` until both are done. The device can stretch the active phase by holding its ready pin low. The same port window also holds a read-only identification/configuration byte and a writable control byte.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset every timer reads 0x00 on the dual variant and 0x08 on the single variant. These are the slowest encodings. The control byte reads 0x00.
- R2: A write whose address has bits [6:2] equal to the base and bit 0 clear reaches timer index {addr[1], addr[7]}. With base 0x30 the timer ports are 0x30, 0xB0, 0x32 and 0xB2, giving indices 0, 1, 2 and 3. The single variant decodes only the ports with addr[1] = 0. A read of a timer port returns the stored byte.
- R3: The byte at base+1 can only be read, and writes to it are ignored. Its fields are: bit 0 = primary IDE port (parameter); bit 1 = base address bit 7; bit 2 = slow bus; bit 3 = disable parameter on the single variant and 1 on the dual variant; bits [7:4] = 1100 for the single variant and 1010 for the dual variant.
- R4: Config bit 2 and the single-variant decode follow the level of `bus_slow_pin` during reset. Changes of the pin after reset have no effect.
- R5: On the dual variant the active count is 17 minus bits [3:0], clamped to 2..17. The recovery count is 15 minus bits [7:4], clamped to 2..15.
- R6: On the single variant with a slow bus, the active count is 9 minus bits [2:0], clamped to 2..9. The recovery count is 15 minus bits [7:4], clamped to 0..15.
- R7: On the single variant with a fast bus, the active count is 8 minus bits [2:0], clamped to 1..8. The recovery count is 18 minus bits [7:4], clamped to 3..18. Timer bit 3 is always stored as 1.
- R8: A write transfer (`xfer_wr` = 1) pulses only `dev_wr_stb`. A read transfer pulses only `dev_rd_stb`.
- R9: On the dual variant, control bit 0 = 1 makes the timer channel equal to `xfer_drive`. Control bit 0 = 0 makes it equal to `xfer_port`. The timer used is the one at base + 2 × channel. The control byte at base+3 can be read and written.
- R10: A request arriving while `xfer_busy` is high is stalled, not dropped. `xfer_busy` is high from acceptance through the end of recovery. The stalled request is accepted on the first cycle the engine is idle, so its strobe starts one cycle after `xfer_busy` falls.
- R11: The counts are fixed when a transfer is accepted. A timer write during a transfer, of a new value or the same value, does not change that transfer; it applies from the next accepted transfer.
- R12: While `dev_rdy` is low, the active phase is held past its programmed count. It ends on the first clock edge at which `dev_rdy` is high and the count is exhausted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_slow_pin | input | 1 | Bus at or below 33 MHz, sampled during reset |
| io_rd | input | 1 | Host I/O read enable |
| io_wr | input | 1 | Host I/O write strobe |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data (0xFF when unmapped or not reading) |
| xfer_req | input | 1 | Transfer request, held until accepted |
| xfer_wr | input | 1 | Transfer direction, 1 = write |
| xfer_port | input | 1 | IDE port of the transfer |
| xfer_drive | input | 1 | Drive number of the transfer |
| xfer_busy | output | 1 | Active or recovery phase in progress |
| dev_rdy | input | 1 | Device ready; low stretches the active phase |
| dev_rd_stb | output | 1 | Read strobe to device, active high |
| dev_wr_stb | output | 1 | Write strobe to device, active high |

## Verification
The checks that run on every cycle cover four things. The strobes must stay quiet whenever the engine is idle, and an acceptance must raise exactly the strobe that matches its direction. A strobe must stay up while the device holds off ready. An active phase can never be shorter than the count captured at acceptance. A timer read on the single variant always shows bit 3 set, and the identification nibble is always correct. Some behaviour only the bench scenarios can show. These are the exact active and recovery lengths for each encoding and speed range, the timer-channel mapping chosen by the control bit, the one-cycle idle gap before a stalled request starts, and the fact that a timer write in the middle of a transfer changes only the next transfer.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

  localparam int CNT_W = 5;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_RECOV  = 2'd2
  } phase_e;

  typedef struct packed {
    cnt_t act;
    cnt_t rec;
  } tmg_t;

  function automatic int clamp_i(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Complemented nibble encoding to clock counts, per variant and bus range
  function automatic tmg_t decode_tmg(input logic [7:0] b, input logic dual,
                                      input logic slow);
    int   a;
    int   r;
    tmg_t t;
    if (dual) begin
      a = clamp_i(17 - int'(b[3:0]), 2, 17);
      r = clamp_i(15 - int'(b[7:4]), 2, 15);
    end else if (slow) begin
      a = clamp_i(9 - int'(b[2:0]), 2, 9);
      r = clamp_i(15 - int'(b[7:4]), 0, 15);
    end else begin
      a = clamp_i(8 - int'(b[2:0]), 1, 8);
      r = clamp_i(18 - int'(b[7:4]), 3, 18);
    end
    t.act = cnt_t'(a);
    t.rec = cnt_t'(r);
    return t;
  endfunction

endpackage

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
  parameter logic [7:0] BASE_ADDR = 8'h30,
  parameter bit         DUAL      = 1'b1,
  parameter bit         PRI_IDE   = 1'b1,
  parameter bit         SGL_OFF   = 1'b0,
  parameter int         N_TMR     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_slow_pin,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [7:0]          io_addr,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic [N_TMR-1:0][7:0] tmr_q,
  output logic                pri_only,
  output logic                slow_bus
);

  localparam logic [4:0] BASE_MID  = BASE_ADDR[6:2];
  localparam logic       BASE_HI   = BASE_ADDR[7];
  localparam logic [7:0] RST_TMG   = DUAL ? 8'h00 : 8'h08;
  localparam logic [7:0] FORCE_SET = DUAL ? 8'h00 : 8'h08;
  localparam logic [3:0] ID_NIB    = DUAL ? 4'b1010 : 4'b1100;
  localparam logic       CFG_B3    = DUAL ? 1'b1 : SGL_OFF;
  localparam int         IDX_W     = $clog2(N_TMR);

  logic             mid_hit, tmr_hit, cfg_hit, ctl_hit;
  logic [IDX_W-1:0] tmr_idx;
  logic [7:0]       ctl_q;
  logic             slow_q;
  logic [7:0]       cfg_byte;

  assign mid_hit = (io_addr[6:2] == BASE_MID);
  assign tmr_hit = mid_hit && !io_addr[0] && (DUAL || !io_addr[1]);
  assign cfg_hit = mid_hit && (io_addr[1:0] == 2'b01) && (io_addr[7] == BASE_HI);
  assign ctl_hit = DUAL && mid_hit && (io_addr[1:0] == 2'b11) && (io_addr[7] == BASE_HI);
  assign tmr_idx = IDX_W'({io_addr[1], io_addr[7]});

  genvar gi;
  generate
    for (gi = 0; gi < N_TMR; gi++) begin : g_tmr
      always_ff @(posedge clk) begin
        if (!rst_n)
          tmr_q[gi] <= RST_TMG;
        else if (io_wr && tmr_hit && (tmr_idx == IDX_W'(gi)))
          tmr_q[gi] <= io_wdata | FORCE_SET;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= 8'h00;
      slow_q <= bus_slow_pin;
    end else if (io_wr && ctl_hit) begin
      ctl_q  <= io_wdata;
    end
  end

  assign cfg_byte = {ID_NIB, CFG_B3, slow_q, BASE_HI, PRI_IDE};

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd) begin
      if (tmr_hit)      io_rdata = tmr_q[tmr_idx];
      else if (cfg_hit) io_rdata = cfg_byte;
      else if (ctl_hit) io_rdata = ctl_q;
    end
  end

  assign pri_only = ctl_q[0];
  assign slow_bus = slow_q;

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_tmg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   dir_wr,
  input  logic   dev_rdy,
  input  tmg_t   tmg,
  output logic   start,
  output phase_e phase,
  output logic   busy,
  output logic   rd_stb,
  output logic   wr_stb
);

  cnt_t cnt_q;
  cnt_t rec_q;
  logic dir_q;

  assign start = req && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      rec_q <= '0;
      dir_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (req) begin
            phase <= PH_ACTIVE;
            cnt_q <= tmg.act - cnt_t'(1);
            rec_q <= tmg.rec;
            dir_q <= dir_wr;
          end
        end
        PH_ACTIVE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - cnt_t'(1);
          end else if (dev_rdy) begin
            if (rec_q == '0) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_RECOV;
              cnt_q <= rec_q - cnt_t'(1);
            end
          end
        end
        PH_RECOV: begin
          if (cnt_q != '0) cnt_q <= cnt_q - cnt_t'(1);
          else             phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign rd_stb = (phase == PH_ACTIVE) && !dir_q;
  assign wr_stb = (phase == PH_ACTIVE) && dir_q;

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_tmg_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h30,
  parameter bit         DUAL      = 1'b1,
  parameter bit         PRI_IDE   = 1'b1,
  parameter bit         SGL_OFF   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_slow_pin,
  input  logic       io_rd,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       xfer_req,
  input  logic       xfer_wr,
  input  logic       xfer_port,
  input  logic       xfer_drive,
  output logic       xfer_busy,
  input  logic       dev_rdy,
  output logic       dev_rd_stb,
  output logic       dev_wr_stb
);

  localparam int   N_TMR   = 4;
  localparam logic BASE_HI = BASE_ADDR[7];

  logic [N_TMR-1:0][7:0] tmr_q;
  logic                  pri_only;
  logic                  slow_bus;
  logic                  eff_chan;
  logic [1:0]            sel_idx;
  tmg_t                  sel_tmg;
  logic                  start;
  phase_e                phase;

  pio_port_regs #(
    .BASE_ADDR(BASE_ADDR), .DUAL(DUAL), .PRI_IDE(PRI_IDE),
    .SGL_OFF(SGL_OFF), .N_TMR(N_TMR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_slow_pin(bus_slow_pin),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .tmr_q(tmr_q), .pri_only(pri_only), .slow_bus(slow_bus)
  );

  // Timer channel: drive number when only the primary port is used, else port
  assign eff_chan = DUAL ? (pri_only ? xfer_drive : xfer_port) : 1'b0;
  assign sel_idx  = {eff_chan, BASE_HI};

  always_comb sel_tmg = decode_tmg(tmr_q[sel_idx], DUAL, slow_bus);

  pio_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(xfer_req), .dir_wr(xfer_wr),
    .dev_rdy(dev_rdy), .tmg(sel_tmg), .start(start), .phase(phase),
    .busy(xfer_busy), .rd_stb(dev_rd_stb), .wr_stb(dev_wr_stb)
  );

endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk
  import pio_tmg_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h30,
  parameter bit         DUAL      = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic [7:0] io_addr,
  input logic [7:0] io_rdata,
  input logic       xfer_wr,
  input logic       xfer_busy,
  input logic       dev_rdy,
  input logic       dev_rd_stb,
  input logic       dev_wr_stb,
  input logic       start,
  input cnt_t       sel_act
);

  localparam logic [7:0] CFG_ADDR = (BASE_ADDR & 8'hFC) | 8'h01;
  localparam logic [3:0] ID_NIB   = DUAL ? 4'b1010 : 4'b1100;

  logic       stb_any;
  logic [7:0] run_len;
  cnt_t       act_need;
  logic       sgl_tmr_rd;

  assign stb_any    = dev_rd_stb || dev_wr_stb;
  assign sgl_tmr_rd = !DUAL && io_rd && (io_addr[6:2] == BASE_ADDR[6:2]) &&
                      (io_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len  <= '0;
      act_need <= '0;
    end else if (start) begin
      run_len  <= '0;
      act_need <= sel_act;
    end else if (stb_any && run_len != 8'hFF) begin
      run_len  <= run_len + 8'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !stb_any);  // R10

  AST_WR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    start && xfer_wr |=> dev_wr_stb && !dev_rd_stb);  // R8

  AST_RD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !xfer_wr |=> dev_rd_stb && !dev_wr_stb);  // R8

  AST_RDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stb_any && !dev_rdy |=> stb_any);  // R12

  AST_ACTIVE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_any) |-> (run_len >= 8'(act_need)));  // R11

  AST_SGL_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    sgl_tmr_rd |-> io_rdata[3]);  // R7

  AST_CFG_ID: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr == CFG_ADDR |-> io_rdata[7:4] == ID_NIB);  // R3

endmodule

bind pio_strobe_timer pio_strobe_timer_chk #(
  .BASE_ADDR(BASE_ADDR), .DUAL(DUAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_addr(io_addr),
  .io_rdata(io_rdata), .xfer_wr(xfer_wr), .xfer_busy(xfer_busy),
  .dev_rdy(dev_rdy), .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
  .start(start), .sel_act(sel_tmg.act)
);

// File: tb/test_pio_strobe_timer.sv
module test_pio_strobe_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_pin = 1'b0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic       req_d = 1'b0, req_s = 1'b0;
  logic       xfer_wr = 1'b0, xfer_port = 1'b0, xfer_drive = 1'b0;
  logic       dev_rdy = 1'b1;
  logic [7:0] rdata_d, rdata_s;
  logic       busy_d, busy_s, rd_d, rd_s, wr_d, wr_s;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pio_strobe_timer #(.BASE_ADDR(8'h30), .DUAL(1'b1)) i_pio_strobe_timer (
    .clk(clk), .rst_n(rst_n), .bus_slow_pin(slow_pin),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(rdata_d), .xfer_req(req_d), .xfer_wr(xfer_wr),
    .xfer_port(xfer_port), .xfer_drive(xfer_drive), .xfer_busy(busy_d),
    .dev_rdy(dev_rdy), .dev_rd_stb(rd_d), .dev_wr_stb(wr_d));

  pio_strobe_timer #(.BASE_ADDR(8'h30), .DUAL(1'b0)) i_pio_strobe_timer_sgl (
    .clk(clk), .rst_n(rst_n), .bus_slow_pin(slow_pin),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(rdata_s), .xfer_req(req_s), .xfer_wr(xfer_wr),
    .xfer_port(xfer_port), .xfer_drive(xfer_drive), .xfer_busy(busy_s),
    .dev_rdy(dev_rdy), .dev_rd_stb(rd_s), .dev_wr_stb(wr_s));

  // mode: 0 dual, 1 single fast bus, 2 single slow bus
  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] tb;
    logic [4:0] act;
    logic [4:0] rec;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h00, 5'd17, 5'd15},
    '{2'd0, 8'hFF, 5'd2,  5'd2 },
    '{2'd0, 8'h5A, 5'd7,  5'd10},
    '{2'd0, 8'hE3, 5'd14, 5'd2 },
    '{2'd0, 8'h1F, 5'd2,  5'd14},
    '{2'd1, 8'h00, 5'd8,  5'd18},
    '{2'd1, 8'hF7, 5'd1,  5'd3 },
    '{2'd1, 8'h35, 5'd3,  5'd15},
    '{2'd2, 8'h00, 5'd9,  5'd15},
    '{2'd2, 8'hF7, 5'd2,  5'd0 },
    '{2'd2, 8'h35, 5'd4,  5'd12}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic slow);
    @(negedge clk);
    rst_n = 1'b0;
    slow_pin = slow;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] vd, output logic [7:0] vs);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    vd = rdata_d; vs = rdata_s;
    io_rd = 1'b0;
  endtask

  task automatic do_xfer(input bit sgl, input bit wr, input bit port, input bit drv,
                         input int extra, input int exp_act,
                         input bit mid_en, input logic [7:0] mid_val,
                         output int n_act, output int n_rec, output int n_wrong);
    logic b, sr, sw;
    @(negedge clk);
    xfer_wr = wr; xfer_port = port; xfer_drive = drv;
    if (extra > 0) dev_rdy = 1'b0;
    if (sgl) req_s = 1'b1; else req_d = 1'b1;
    n_act = 0; n_rec = 0; n_wrong = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      io_wr = 1'b0;
      req_s = 1'b0; req_d = 1'b0;
      b  = sgl ? busy_s : busy_d;
      sr = wr ? (sgl ? wr_s : wr_d) : (sgl ? rd_s : rd_d);
      sw = wr ? (sgl ? rd_s : rd_d) : (sgl ? wr_s : wr_d);
      if (!b) break;
      if (sw) n_wrong++;
      if (sr) begin
        n_act++;
        if (mid_en && n_act == 2) begin
          io_addr = 8'h30; io_wdata = mid_val; io_wr = 1'b1;
        end
        if (extra > 0 && n_act == exp_act + extra) dev_rdy = 1'b1;
      end else begin
        n_rec++;
      end
    end
    dev_rdy = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] vd, vs;
    int na, nr, nw;
    bit slow_done;
    logic [7:0] stb_tr, bsy_tr;

    do_reset(1'b0);

    // R1 reset state
    io_read(8'h30, vd, vs); chk(vd == 8'h00, "R1 dual timer0", vd, 8'h00);
    chk(vs == 8'h08, "R1 single timer0", vs, 8'h08);
    io_read(8'hB2, vd, vs); chk(vd == 8'h00, "R1 dual timer3", vd, 8'h00);
    io_read(8'h33, vd, vs); chk(vd == 8'h00, "R1 control", vd, 8'h00);

    // R3 config byte, read-only
    io_read(8'h31, vd, vs); chk(vd == 8'hA9, "R3 dual config", vd, 8'hA9);
    chk(vs == 8'hC1, "R3 single config", vs, 8'hC1);
    io_write(8'h31, 8'h00);
    io_read(8'h31, vd, vs); chk(vd == 8'hA9, "R3 config write ignored", vd, 8'hA9);

    // R4 pin change after reset has no effect
    slow_pin = 1'b1;
    io_read(8'h31, vd, vs); chk(vd == 8'hA9, "R4 pin after reset", vd, 8'hA9);
    slow_pin = 1'b0;

    // R2 timer address decode
    io_write(8'h30, 8'h11); io_write(8'hB0, 8'h22);
    io_write(8'h32, 8'h33); io_write(8'hB2, 8'h44);
    io_read(8'h30, vd, vs); chk(vd == 8'h11, "R2 idx0", vd, 8'h11);
    io_read(8'hB0, vd, vs); chk(vd == 8'h22, "R2 idx1", vd, 8'h22);
    io_read(8'h32, vd, vs); chk(vd == 8'h33, "R2 idx2", vd, 8'h33);
    io_read(8'hB2, vd, vs); chk(vd == 8'h44, "R2 idx3", vd, 8'h44);
    chk(vs == 8'hFF, "R2 single no timer2", vs, 8'hFF);

    // R9 channel mapping by control bit 0
    io_write(8'h30, 8'h00); io_write(8'h32, 8'hFF);
    do_xfer(0, 0, 1, 0, 0, 0, 0, 8'h00, na, nr, nw); chk(na == 2, "R9 port map port1", na, 2);
    do_xfer(0, 0, 0, 1, 0, 0, 0, 8'h00, na, nr, nw); chk(na == 17, "R9 port map drive1", na, 17);
    io_write(8'h33, 8'h01);
    io_read(8'h33, vd, vs); chk(vd == 8'h01, "R9 control readback", vd, 8'h01);
    do_xfer(0, 0, 0, 1, 0, 0, 0, 8'h00, na, nr, nw); chk(na == 2, "R9 drive map drive1", na, 2);
    do_xfer(0, 0, 1, 0, 0, 0, 0, 8'h00, na, nr, nw); chk(na == 17, "R9 drive map port1", na, 17);
    io_write(8'h33, 8'h00);

    // R10 stalled request accepted after recovery, one idle cycle
    io_write(8'h30, 8'hFF);
    @(negedge clk);
    xfer_wr = 1'b1; xfer_port = 1'b0; xfer_drive = 1'b0; req_d = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      stb_tr[k] = wr_d;
      bsy_tr[k] = busy_d;
      if (k == 5) req_d = 1'b0;
    end
    chk(stb_tr == 8'b0110_0011, "R10 strobe trace", stb_tr, 8'b0110_0011);
    chk(bsy_tr == 8'b1110_1111, "R10 busy trace", bsy_tr, 8'b1110_1111);
    repeat (4) @(negedge clk);

    // R11 timing fixed at accept; mid-transfer write applies next
    io_write(8'h30, 8'h00);
    do_xfer(0, 1, 0, 0, 0, 0, 1, 8'hFF, na, nr, nw);
    chk(na == 17, "R11 active unchanged", na, 17);
    chk(nr == 15, "R11 recovery unchanged", nr, 15);
    do_xfer(0, 1, 0, 0, 0, 0, 1, 8'hFF, na, nr, nw);
    chk(na == 2, "R11 new active next", na, 2);
    chk(nr == 2, "R11 same-value rewrite", nr, 2);

    // R12 ready low stretches active phase
    do_xfer(0, 0, 0, 0, 3, 2, 0, 8'h00, na, nr, nw);
    chk(na == 5, "R12 stretched active", na, 5);
    chk(nr == 2, "R12 recovery after stretch", nr, 2);

    // Vector table: encodings per variant and bus speed (R5 R6 R7 R8)
    slow_done = 0;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] exp_rb;
      if (VECS[i].mode == 2'd2 && !slow_done) begin
        slow_done = 1;
        do_reset(1'b1);
        io_read(8'h31, vd, vs);
        chk(vs == 8'hC5, "R4 slow single config", vs, 8'hC5);
        chk(vd == 8'hAD, "R4 slow dual config", vd, 8'hAD);
      end
      io_write(8'h30, VECS[i].tb);
      io_read(8'h30, vd, vs);
      exp_rb = VECS[i].tb | ((VECS[i].mode != 2'd0) ? 8'h08 : 8'h00);
      if (VECS[i].mode == 2'd0) chk(vd == exp_rb, "R2 dual readback", vd, exp_rb);
      else                      chk(vs == exp_rb, "R7 single bit3 readback", vs, exp_rb);
      do_xfer(VECS[i].mode != 2'd0, i[0], 0, 0, 0, 0, 0, 8'h00, na, nr, nw);
      case (VECS[i].mode)
        2'd0: begin
          chk(na == int'(VECS[i].act), "R5 dual active", na, VECS[i].act);
          chk(nr == int'(VECS[i].rec), "R5 dual recovery", nr, VECS[i].rec);
        end
        2'd1: begin
          chk(na == int'(VECS[i].act), "R7 fast active", na, VECS[i].act);
          chk(nr == int'(VECS[i].rec), "R7 fast recovery", nr, VECS[i].rec);
        end
        default: begin
          chk(na == int'(VECS[i].act), "R6 slow active", na, VECS[i].act);
          chk(nr == int'(VECS[i].rec), "R6 slow recovery", nr, VECS[i].rec);
        end
      endcase
      chk(nw == 0, "R8 opposite strobe quiet", nw, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule